// File: doc/BRIEF.md
# Multi-Channel Timer with Capture, Compare and PWM

This block is a 16-bit timer in which one shared counter serves a set of channels. The counter steps on a tick from a power-of-two prescaler. It either counts upward and wraps, or counts upward and then downward between zero and a top value. The top value is a programmed modulo, or the full 16-bit range when the modulo is zero. Each time the counter returns to zero a terminal-count flag is raised, and that flag can request an interrupt.

Each channel has its own mode. In capture mode it records the counter value when a selected edge arrives on its input pin; the pin is first passed through a two-stage synchronizer. In compare mode it toggles, clears or sets its output pin when the counter equals the channel value. In PWM mode it produces an edge-aligned waveform with selectable polarity. A channel value written in PWM mode is held in a shadow register and becomes active at the next terminal count. Every channel has an event flag and an interrupt enable. Software drives a simple write port and reads the live count and the active channel values.

Counter states: IDLE (disabled), UP, DOWN. The transitions are:
- IDLE→UP when enabled.
- UP→UP on each tick, and on the wrap to zero in up-only mode.
- UP→DOWN at the top value in up/down mode.
- DOWN→UP at zero, or when up/down mode is switched off.
- UP or DOWN→IDLE when disabled.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset the count is 0, all channel pins are low, and all channel flags, channel interrupts, the terminal-count flag and the terminal-count interrupt are 0.
- R2: Control register at address 0 has these bits: bit0 enable, bit1 up/down, bits[4:2] prescale select p, bit5 terminal-count interrupt enable. While bit0 is 0 the count holds. While it is 1 the count advances once every 2^p clocks.
- R3: Modulo register at address 1. In up-only mode the count runs 0..top and then returns to 0. top is the modulo, or 0xFFFF when the modulo is 0.
- R4: In up/down mode the count steps by exactly one. It turns downward at top and upward at 0, so its extremes are top and 0.
- R5: The terminal-count flag sets whenever the count moves from a non-zero value to 0. Writing 1 to bit15 at address 2 clears it. The terminal-count interrupt equals the flag AND control bit5.
- R6: Channel k configuration is at address 4+2k: bits[1:0] mode (0 off, 1 capture, 2 compare, 3 PWM), bits[3:2] select, bit4 interrupt enable. In capture mode, select 1 captures on rising edges, 2 on falling edges and 3 on both. The count is copied into the channel value and an edge of the other kind changes nothing.
- R7: In compare mode, when the count equals the channel value the pin toggles (select 1), clears (select 2) or sets (select 3). It holds between matches.
- R8: In PWM mode the pin is high from count 0 until the count equals the value. A value of 0 gives a constantly low pin, and a value above top gives a constantly high pin. Select bit0 = 1 inverts the pin.
- R9: The channel value is at address 5+2k. In PWM mode a write there becomes active only at the next return of the count to 0. In other modes it takes effect at once.
- R10: Each channel event (capture, or a match in compare or PWM mode) sets that channel's flag. Writing 1 to bit k at address 2 clears it. The channel interrupt equals the flag AND configuration bit4.
- R11: A channel in off mode drives its pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| cap_in | input | NCH | Channel input pins |
| ch_out | output | NCH | Channel output pins |
| ch_flag | output | NCH | Channel event flags |
| ch_irq | output | NCH | Channel interrupt requests |
| tc_flag | output | 1 | Terminal-count flag |
| tc_irq | output | 1 | Terminal-count interrupt request |
| count | output | 16 | Live counter value |
| ch_val | output | NCH*16 | Active channel values, channel k in bits [16k+15:16k] |

## Verification
Two situations are hard to reach from the ports.

The first is the wrap from 0xFFFF with a zero modulo. It takes a full 65536-tick run, so the stimulus leaves the counter free-running until the count reads 0xFFFF and then checks the next sample.

The second is a capture that is checked exactly against a moving counter. The three-stage input path makes the captured value depend on the cycle in which the edge arrives. The stimulus therefore stops the counter through the enable bit before driving an edge, so the expected value is the frozen count. Between edges it lets the counter run briefly so that every capture has a distinct value.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_COMPARE = 2'd2,
        CH_PWM     = 2'd3
    } ch_mode_e;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_UP   = 2'd1,
        CT_DOWN = 2'd2
    } cnt_state_e;

    localparam int ADDR_W    = 5;
    localparam int A_CTRL    = 0;
    localparam int A_MOD     = 1;
    localparam int A_CLR     = 2;
    localparam int A_CH_BASE = 4;
endpackage

// File: rtl/pwmcap_prescale.sv
module pwmcap_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [PSW-1:0] psel,
    output logic           tick
);
    localparam int DW = (1 << PSW) - 1;

    logic [DW-1:0] div_q;
    logic [DW-1:0] mask;

    assign mask = DW'((32'd1 << psel) - 32'd1);
    assign tick = en && ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_q <= '0;
        else if (!en) div_q <= '0;
        else          div_q <= div_q + 1'b1;
    end

    // R2: a divided tick never lasts two clocks while the division holds
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0) |=> (!tick || psel != $past(psel)));
endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter
    import pwmcap_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          updown,
    input  logic          tick,
    input  logic [CW-1:0] modulo,
    output logic [CW-1:0] cnt_q,
    output logic          upd_q,
    output logic          tc_q
);
    cnt_state_e    st_q, st_n;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] top;
    logic          step;
    logic          tc_n;

    assign top  = (modulo == '0) ? '1 : modulo;
    assign step = en && tick && (st_q != CT_IDLE);
    assign tc_n = step && (cnt_n == '0) && (cnt_q != '0);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            CT_IDLE: begin
                if (en) st_n = CT_UP;
            end
            CT_UP: begin
                if (!en) begin
                    st_n = CT_IDLE;
                end else if (tick) begin
                    if (cnt_q >= top) begin
                        if (updown) begin
                            cnt_n = top - 1'b1;
                            st_n  = CT_DOWN;
                        end else begin
                            cnt_n = '0;
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            CT_DOWN: begin
                if (!en) begin
                    st_n = CT_IDLE;
                end else if (tick) begin
                    if (cnt_q == '0 || !updown) begin
                        st_n  = CT_UP;
                        cnt_n = (cnt_q >= top) ? '0 : cnt_q + 1'b1;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
            end
            default: st_n = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            tc_q  <= 1'b0;
        end else begin
            upd_q <= step;
            tc_q  <= tc_n;
        end
    end

    // R2: disabled counter holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
    // R5: terminal-count strobe only accompanies a zero count
    a_r5_tc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |-> (cnt_q == '0));
    // R3 / R4: each update moves by one or returns to zero
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1 || cnt_q == '0));
endmodule

// File: rtl/pwmcap_channel.sv
module pwmcap_channel
    import pwmcap_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          val_we,
    input  logic          flag_clr,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] cnt,
    input  logic          upd,
    input  logic          tc,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          flag,
    output logic          irq,
    output logic [CW-1:0] val
);
    logic [4:0]    cfg_q;
    ch_mode_e      mode;
    logic [1:0]    sel;
    logic          ie;
    logic [CW-1:0] act_q, buf_q, val_eff;
    logic [2:0]    sync_q;
    logic          rise, fall, cap_ev, hit, tcv, ev;
    logic          lvl_q, flag_q;

    assign mode = ch_mode_e'(cfg_q[1:0]);
    assign sel  = cfg_q[3:2];
    assign ie   = cfg_q[4];

    assign rise    = sync_q[1] && !sync_q[2];
    assign fall    = !sync_q[1] && sync_q[2];
    assign cap_ev  = (mode == CH_CAPTURE) && ((sel[0] && rise) || (sel[1] && fall));
    assign tcv     = upd && tc;
    assign val_eff = (mode == CH_PWM && tcv) ? buf_q : act_q;
    assign hit     = upd && (cnt == val_eff);
    assign ev      = cap_ev || (hit && (mode == CH_COMPARE || mode == CH_PWM));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            sync_q <= '0;
            act_q  <= '0;
            buf_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], pin_in};
            if (cfg_we) cfg_q <= wdata[4:0];
            if (val_we) buf_q <= wdata;
            if (cap_ev)                          act_q <= cnt;
            else if (val_we && mode != CH_PWM)   act_q <= wdata;
            else if (mode == CH_PWM && tcv)      act_q <= buf_q;
            if (ev)            flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            unique case (mode)
                CH_OFF, CH_CAPTURE: lvl_q <= 1'b0;
                CH_COMPARE: begin
                    if (hit) begin
                        unique case (sel)
                            2'd1:    lvl_q <= !lvl_q;
                            2'd2:    lvl_q <= 1'b0;
                            2'd3:    lvl_q <= 1'b1;
                            default: lvl_q <= lvl_q;
                        endcase
                    end
                end
                CH_PWM: begin
                    if (hit)      lvl_q <= 1'b0;
                    else if (tcv) lvl_q <= 1'b1;
                end
                default: lvl_q <= 1'b0;
            endcase
        end
    end

    assign pin_out = (mode == CH_PWM) ? (lvl_q ^ sel[0]) : lvl_q;
    assign flag    = flag_q;
    assign irq     = flag_q && ie;
    assign val     = act_q;

    // R6: a capture event stores the count seen at that edge
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (act_q == $past(cnt)));
    // R10: any channel event leaves the flag set
    a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag_q);
    // R11: off mode forces the pin level low
    a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_OFF) |=> !lvl_q);
    // R7: set-on-match leaves the pin high
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CH_COMPARE && hit && sel == 2'd3) |=> lvl_q);
endmodule

// File: rtl/pwmcap_timer.sv
module pwmcap_timer
    import pwmcap_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PSW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [NCH-1:0]    cap_in,
    output logic [NCH-1:0]    ch_out,
    output logic [NCH-1:0]    ch_flag,
    output logic [NCH-1:0]    ch_irq,
    output logic              tc_flag,
    output logic              tc_irq,
    output logic [CW-1:0]     count,
    output logic [NCH*CW-1:0] ch_val
);
    localparam int CTRL_W = PSW + 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CW-1:0]     mod_q;
    logic              tc_flag_q;
    logic              tick, upd, tc_pulse;
    logic              clr_we;
    logic [CW-1:0]     cnt;

    assign clr_we = wr_en && (wr_addr == ADDR_W'(A_CLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mod_q     <= '0;
            tc_flag_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_en && wr_addr == ADDR_W'(A_MOD))  mod_q  <= wr_data;
            if (tc_pulse)                        tc_flag_q <= 1'b1;
            else if (clr_we && wr_data[CW-1])    tc_flag_q <= 1'b0;
        end
    end

    pwmcap_prescale #(.PSW(PSW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_q[0]),
        .psel (ctrl_q[2 +: PSW]),
        .tick (tick)
    );

    pwmcap_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_q[0]),
        .updown(ctrl_q[1]),
        .tick  (tick),
        .modulo(mod_q),
        .cnt_q (cnt),
        .upd_q (upd),
        .tc_q  (tc_pulse)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic cfg_we, val_we;
        assign cfg_we = wr_en && (wr_addr == ADDR_W'(A_CH_BASE + 2 * k));
        assign val_we = wr_en && (wr_addr == ADDR_W'(A_CH_BASE + 2 * k + 1));

        pwmcap_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .val_we  (val_we),
            .flag_clr(clr_we && wr_data[k]),
            .wdata   (wr_data),
            .cnt     (cnt),
            .upd     (upd),
            .tc      (tc_pulse),
            .pin_in  (cap_in[k]),
            .pin_out (ch_out[k]),
            .flag    (ch_flag[k]),
            .irq     (ch_irq[k]),
            .val     (ch_val[k*CW +: CW])
        );
    end

    assign tc_flag = tc_flag_q;
    assign tc_irq  = tc_flag_q && ctrl_q[CTRL_W-1];
    assign count   = cnt;

    // R5: a terminal count always leaves the flag raised
    a_r5_tc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> tc_flag_q);
endmodule

// File: tb/tb_pwmcap_timer.sv
module tb_pwmcap_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [NCH-1:0]    cap_in = '0;
    logic [NCH-1:0]    ch_out, ch_flag, ch_irq;
    logic              tc_flag, tc_irq;
    logic [15:0]       count;
    logic [NCH*16-1:0] ch_val;

    always #(CLK_PERIOD/2) clk = !clk;

    pwmcap_timer #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_in(cap_in), .ch_out(ch_out), .ch_flag(ch_flag), .ch_irq(ch_irq),
        .tc_flag(tc_flag), .tc_irq(tc_irq), .count(count), .ch_val(ch_val)
    );

    // scoreboard queues: selector 0 count, 1 ch value, 2 pin, 3 flag, 4 irq, 5 tc flag, 6 tc irq, 7 given
    string       q_req[$];
    int          q_sel[$];
    int          q_idx[$];
    logic [31:0] q_exp[$];
    logic [31:0] q_act[$];
    int          sb_n = 0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    task automatic push(input string req, input int sel, input int idx,
                        input logic [31:0] exp, input logic [31:0] act);
        q_req.push_back(req); q_sel.push_back(sel); q_idx.push_back(idx);
        q_exp.push_back(exp); q_act.push_back(act);
        sb_n++;
        wait (sb_n == 0);
    endtask

    task automatic chk(input string req, input int sel, input int idx, input logic [31:0] exp);
        push(req, sel, idx, exp, 32'd0);
    endtask

    task automatic given(input string req, input logic [31:0] act, input logic [31:0] exp);
        push(req, 7, 0, exp, act);
    endtask

    always begin : monitor
        string       r;
        int          s, i;
        logic [31:0] e, a;
        wait (sb_n > 0);
        @(negedge clk);
        r = q_req.pop_front(); s = q_sel.pop_front(); i = q_idx.pop_front();
        e = q_exp.pop_front(); a = q_act.pop_front();
        case (s)
            0: a = {16'd0, count};
            1: a = {16'd0, ch_val[i*16 +: 16]};
            2: a = {31'd0, ch_out[i]};
            3: a = {31'd0, ch_flag[i]};
            4: a = {31'd0, ch_irq[i]};
            5: a = {31'd0, tc_flag};
            6: a = {31'd0, tc_irq};
            default: ;
        endcase
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s sel=%0d idx=%0d actual=%0h expected=%0h", r, s, i, a, e);
        end
        sb_n--;
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic duty(input int ch, input int n, output int highs);
        highs = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (ch_out[ch]) highs++;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin : driver
        int prev, cur, errs, mx, mn, gap, h, c0, c1, c2;
        tk(5);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", 0, 0, 0);
        chk("R1 pins", 2, 0, 0);
        chk("R1 pins", 2, 3, 0);
        chk("R1 flag", 3, 1, 0);
        chk("R1 irq", 4, 2, 0);
        chk("R1 tc flag", 5, 0, 0);
        chk("R1 tc irq", 6, 0, 0);
        // R2 disabled counter holds
        tk(8);
        chk("R2 hold while disabled", 0, 0, 0);

        // R3 up-only with modulo 9
        wr(1, 16'd9);
        wr(0, 16'h0021);
        tk(3);
        errs = 0; mx = 0; prev = count;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            cur = count;
            if (cur != (prev + 1) % 10) errs++;
            if (cur > mx) mx = cur;
            prev = cur;
        end
        given("R3 up sequence errors", errs, 0);
        given("R3 maximum equals modulo", mx, 9);
        // R5 terminal count flag and interrupt
        chk("R5 tc flag set", 5, 0, 1);
        chk("R5 tc irq", 6, 0, 1);
        wr(0, 16'h0020);
        wr(2, 16'h8000);
        chk("R5 tc flag cleared", 5, 0, 0);
        chk("R5 tc irq cleared", 6, 0, 0);
        wr(0, 16'h0001);
        tk(20);
        chk("R5 flag without enable", 5, 0, 1);
        chk("R5 irq gated by enable", 6, 0, 0);

        // R2 prescaler divide by 4
        wr(0, 16'h0009);
        prev = count; gap = 0;
        for (int j = 0; j < 20 && count == prev; j++) @(negedge clk);
        prev = count;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            gap++;
            if (count != prev) break;
        end
        given("R2 prescale interval", gap, 4);

        // R4 up/down with modulo 5
        wr(0, 16'h0000);
        wr(1, 16'd5);
        wr(0, 16'h0003);
        tk(15);
        errs = 0; mx = 0; mn = 99; prev = count;
        for (int j = 0; j < 60; j++) begin
            @(negedge clk);
            cur = count;
            if (cur != prev + 1 && cur != prev - 1) errs++;
            if (cur > mx) mx = cur;
            if (cur < mn) mn = cur;
            prev = cur;
        end
        given("R4 single steps", errs, 0);
        given("R4 upper turn", mx, 5);
        given("R4 lower turn", mn, 0);
        wr(2, 16'h8000);
        tk(15);
        chk("R5 tc in up/down", 5, 0, 1);

        // R3 free-running wrap with modulo 0
        wr(0, 16'h0000);
        wr(1, 16'd0);
        wr(0, 16'h0001);
        for (int j = 0; j < 70000 && count != 16'hFFFF; j++) @(negedge clk);
        chk("R3 wrap from 0xFFFF", 0, 0, 0);

        // R6 capture with frozen counter
        tk(10);
        wr(0, 16'h0000);
        tk(1);
        c0 = count;
        wr(4, 16'h0015);
        wr(8, 16'h0009);
        wr(9, 16'h1234);
        cap_in[0] = 1'b1;
        tk(5);
        chk("R6 rising capture", 1, 0, 32'(c0));
        chk("R10 capture flag", 3, 0, 1);
        chk("R10 capture irq", 4, 0, 1);
        wr(0, 16'h0001); tk(7); wr(0, 16'h0000); tk(1);
        c1 = count;
        cap_in[0] = 1'b0;
        tk(5);
        chk("R6 falling ignored on rising-only", 1, 0, 32'(c0));
        wr(6, 16'h000D);
        cap_in[1] = 1'b1;
        tk(5);
        chk("R6 both-edge rising", 1, 1, 32'(c1));
        wr(0, 16'h0001); tk(9); wr(0, 16'h0000); tk(1);
        c2 = count;
        cap_in[1] = 1'b0;
        tk(5);
        chk("R6 both-edge falling", 1, 1, 32'(c2));
        cap_in[2] = 1'b1;
        tk(5);
        chk("R6 rising ignored on falling-only", 1, 2, 32'h1234);
        cap_in[2] = 1'b0;
        tk(5);
        chk("R6 falling-only capture", 1, 2, 32'(c2));
        // R10 flag clear and interrupt enable
        wr(2, 16'h0001);
        chk("R10 flag cleared", 3, 0, 0);
        chk("R10 irq cleared", 4, 0, 0);
        chk("R10 flag without enable", 3, 1, 1);
        chk("R10 irq gated", 4, 1, 0);

        // R7 compare actions
        wr(1, 16'd9);
        wr(9, 16'd3);
        wr(8, 16'h0006);
        wr(0, 16'h0001);
        tk(12);
        errs = 0; prev = ch_out[2];
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (ch_out[2] != prev[0]) errs++;
            prev = ch_out[2];
        end
        given("R7 toggles per 30 cycles", errs, 3);
        wr(8, 16'h000E);
        tk(12);
        chk("R7 set on match", 2, 2, 1);
        tk(20);
        chk("R7 set holds", 2, 2, 1);
        wr(8, 16'h000A);
        tk(12);
        chk("R7 clear on match", 2, 2, 0);

        // R8 PWM duty
        wr(10, 16'h0003);
        wr(11, 16'd4);
        tk(25); duty(3, 10, h);
        given("R8 duty 4 of 10", h, 4);
        wr(11, 16'd0);
        tk(25); duty(3, 10, h);
        given("R8 zero value low", h, 0);
        wr(11, 16'd12);
        tk(25); duty(3, 10, h);
        given("R8 above top high", h, 10);
        wr(11, 16'd4);
        wr(10, 16'h0007);
        tk(25); duty(3, 10, h);
        given("R8 inverted polarity", h, 6);

        // R9 buffered PWM value
        wr(10, 16'h0003);
        wr(1, 16'd99);
        wr(11, 16'd20);
        tk(210);
        chk("R9 value active", 1, 3, 20);
        for (int j = 0; j < 200 && count != 16'd10; j++) @(negedge clk);
        wr(11, 16'd50);
        chk("R9 write held until terminal count", 1, 3, 20);
        for (int j = 0; j < 200 && count != 16'd0; j++) @(negedge clk);
        tk(2);
        chk("R9 write applied at terminal count", 1, 3, 50);

        // R11 off mode
        wr(10, 16'h0000);
        tk(2);
        chk("R11 pin low when off", 2, 3, 0);
        duty(3, 100, h);
        given("R11 stays low", h, 0);

        wait (sb_n == 0);
        report();
        $finish;
    end
endmodule